// File: doc/BRIEF.md
# HDLC Frame Check Sequence Checker with Serial Test Access

This block checks the 16-bit frame check sequence of an HDLC receiver. The bits of each received frame arrive one per enabled receive clock, least significant bit of each octet first, with flags and stuffed zeros already removed. They pass through a CRC-16 built on x^16+x^12+x^5+1. A start strobe presets the register before a frame. An end strobe latches a pass or fail verdict, and the verdict stays on the output until the next end strobe. A frame that ends with its complemented check sequence leaves the fixed residue 0xF0B8 in the register.

Two test features make the comparator reachable without building real frames. With the test enable high, the serial input is shifted straight into the comparison register with no feedback. After sixteen shifts the shifting stops and the register holds a chosen pattern. A 16-bit corrupt mask inverts any chosen remainder bits before the comparison, so a correct frame can be forced to fail, and a known wrong remainder can be made to pass.

Top module: `fcs_checker`

## Requirements
- R1: In normal mode, each cycle with `bit_en` high feeds `rx_bit` into the CRC. The register shifts toward bit 0, and when bit0 XOR `rx_bit` is 1 it is XORed with 0x8408. This is x^16+x^12+x^5+1 taken least significant bit first. With no strobe and no `bit_en`, the register is unchanged.
- R2: In normal mode, `frm_start` presets the register to 0xFFFF. It wins over a `bit_en` in the same cycle, and that bit is discarded.
- R3: On `frm_end`, `crc_ok` is set to ((register XOR `corrupt_mask`) == 0xF0B8). The register value used is the one before any bit arriving in the same cycle. `crc_ok` appears after that clock edge and holds until the next `frm_end`.
- R4: A frame sent as preset, data octets, then the complemented CRC (low octet first, every octet least significant bit first) gives `crc_ok`=1 with a zero mask. The same frame with any single bit inverted gives 0.
- R5: A mask bit at 1 inverts the matching remainder bit before the comparison. A correct frame with a nonzero mask fails. A frame whose remainder differs from 0xF0B8 in exactly the masked bits passes.
- R6: While `test_en` is high and fewer than 16 test shifts have taken place, each `bit_en` moves `rx_bit` into bit 15 and every other bit down by one, with no feedback. After 16 shifts the k-th bit shifted in sits at bit k.
- R7: While `test_en` is high, `frm_start` has no effect. After 16 test shifts, further `bit_en` cycles do not change the register either.
- R8: Lowering `test_en` rearms the 16-shift count. The register keeps its content until the next `frm_start` or `bit_en`. A new test session shifts in another 16 bits.
- R9: After reset, `crc_ok` is 0 and the register holds 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Receive bit enable: one serial bit is valid this cycle |
| rx_bit | input | 1 | Serial frame or test data bit |
| frm_start | input | 1 | Start-of-frame strobe, presets the CRC |
| frm_end | input | 1 | End-of-frame strobe, latches the verdict |
| test_en | input | 1 | Serial test access to the comparison register |
| corrupt_mask | input | 16 | Per-bit remainder inversion before comparison |
| crc_ok | output | 1 | Latched frame check verdict |

## Verification
Assertions check these behaviours on every cycle:
- the preset on a start strobe;
- the plain shift-in path in test mode and the freeze once 16 shifts are done;
- the bound on the shift counter and its clearing when test mode drops;
- `crc_ok` holding between end strobes.

Only the bench scenarios can show the arithmetic claims. Complete frames must leave the 0xF0B8 residue, and single-bit errors must be caught. Masks must move the verdict as stated, and a bit arriving with the end strobe must be excluded. These checks are made against a CRC model and a serial pattern that the bench computes for itself.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int          FCS_W       = 16;
  localparam logic [15:0] FCS_POLY_LSB = 16'h8408;
  localparam logic [15:0] FCS_PRESET   = 16'hFFFF;
  localparam logic [15:0] FCS_RESIDUE  = 16'hF0B8;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_HOLD  = 2'd2
  } fcs_mode_e;
endpackage

// File: rtl/fcs_test_seq.sv
module fcs_test_seq
  import fcs_pkg::*;
#(
  parameter int W = FCS_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      test_en,
  input  logic      bit_en,
  output fcs_mode_e mode
);
  localparam int             CW      = $clog2(W + 1);
  localparam logic [CW-1:0]  CNT_MAX = CW'(W);

  logic [CW-1:0] cnt_q, cnt_nx;
  logic          done;

  assign done = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_nx = cnt_q;
    if (!test_en)            cnt_nx = '0;
    else if (bit_en && !done) cnt_nx = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  always_comb begin
    if (!test_en)  mode = MODE_RUN;
    else if (done) mode = MODE_HOLD;
    else           mode = MODE_SHIFT;
  end

  // R7: the shift count never passes the register width
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R8: leaving test mode rearms the count
  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> cnt_q == '0);
endmodule

// File: rtl/fcs_shift_reg.sv
module fcs_shift_reg
  import fcs_pkg::*;
#(
  parameter int           W      = FCS_W,
  parameter logic [W-1:0] POLY   = FCS_POLY_LSB,
  parameter logic [W-1:0] PRESET = FCS_PRESET
) (
  input  logic         clk,
  input  logic         rst_n,
  input  fcs_mode_e    mode,
  input  logic         bit_en,
  input  logic         rx_bit,
  input  logic         frm_start,
  output logic [W-1:0] crc_q
);
  logic [W-1:0] crc_nx;
  logic         fb;

  assign fb = crc_q[0] ^ rx_bit;

  always_comb begin
    crc_nx = crc_q;
    unique case (mode)
      MODE_RUN: begin
        if (frm_start)   crc_nx = PRESET;
        else if (bit_en) crc_nx = (crc_q >> 1) ^ (fb ? POLY : '0);
      end
      MODE_SHIFT: begin
        if (bit_en) crc_nx = {rx_bit, crc_q[W-1:1]};
      end
      default: crc_nx = crc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= PRESET;
    else        crc_q <= crc_nx;
  end

  // R2: start strobe in normal mode presets the register
  a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && frm_start) |=> crc_q == PRESET);
  // R1: no enable and no strobe leaves the register alone
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RUN && !frm_start && !bit_en) |=> $stable(crc_q));
  // R6: a test shift moves the serial bit into the top position
  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHIFT && bit_en) |=>
      (crc_q[W-1] == $past(rx_bit)) && (crc_q[W-2:0] == $past(crc_q[W-1:1])));
  // R7: once the test shifts are complete the register is frozen
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(crc_q));
endmodule

// File: rtl/fcs_judge.sv
module fcs_judge
  import fcs_pkg::*;
#(
  parameter int           W       = FCS_W,
  parameter logic [W-1:0] RESIDUE = FCS_RESIDUE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frm_end,
  input  logic [W-1:0] crc_q,
  input  logic [W-1:0] corrupt_mask,
  output logic         crc_ok
);
  logic ok_q, ok_nx;

  always_comb begin
    ok_nx = ok_q;
    if (frm_end) ok_nx = ((crc_q ^ corrupt_mask) == RESIDUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_q <= 1'b0;
    else        ok_q <= ok_nx;
  end

  assign crc_ok = ok_q;

  // R3: the verdict only moves on an end strobe
  a_r3_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_end |=> $stable(crc_ok));
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
#(
  parameter int           W       = FCS_W,
  parameter logic [W-1:0] POLY    = FCS_POLY_LSB,
  parameter logic [W-1:0] PRESET  = FCS_PRESET,
  parameter logic [W-1:0] RESIDUE = FCS_RESIDUE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         rx_bit,
  input  logic         frm_start,
  input  logic         frm_end,
  input  logic         test_en,
  input  logic [W-1:0] corrupt_mask,
  output logic         crc_ok
);
  fcs_mode_e    mode;
  logic [W-1:0] crc_q;

  fcs_test_seq #(.W(W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .test_en (test_en),
    .bit_en  (bit_en),
    .mode    (mode)
  );

  fcs_shift_reg #(.W(W), .POLY(POLY), .PRESET(PRESET)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .bit_en    (bit_en),
    .rx_bit    (rx_bit),
    .frm_start (frm_start),
    .crc_q     (crc_q)
  );

  fcs_judge #(.W(W), .RESIDUE(RESIDUE)) u_judge (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_end      (frm_end),
    .crc_q        (crc_q),
    .corrupt_mask (corrupt_mask),
    .crc_ok       (crc_ok)
  );

  // R7: start strobe is ignored for the whole test session
  a_r7_no_preset_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && frm_start && !bit_en) |=> $stable(crc_q));
endmodule

// File: tb/fcs_checker_test.sv
module fcs_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic        rx_bit = 1'b0;
  logic        frm_start = 1'b0;
  logic        frm_end = 1'b0;
  logic        test_en = 1'b0;
  logic [15:0] corrupt_mask = 16'h0;
  logic        crc_ok;

  int total = 0;
  int bad = 0;

  logic [7:0]  data [0:15];
  logic [15:0] last_rem;
  logic [15:0] rem_before;

  localparam logic [15:0] GOOD = 16'hF0B8;

  always #10 clk = ~clk;

  fcs_checker uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frm_start(frm_start), .frm_end(frm_end), .test_en(test_en),
    .corrupt_mask(corrupt_mask), .crc_ok(crc_ok)
  );

  function automatic logic [15:0] step(input logic [15:0] c, input logic b);
    logic f;
    f = c[0] ^ b;
    return (c >> 1) ^ (f ? 16'h8408 : 16'h0);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: crc_ok=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic en, input logic b, input logic s, input logic e);
    bit_en = en; rx_bit = b; frm_start = s; frm_end = e;
    @(negedge clk);
    bit_en = 1'b0; frm_start = 1'b0; frm_end = 1'b0;
  endtask

  // sends start, n data octets and the complemented FCS; bit index flip is inverted
  task automatic send_frame(input int n, input int flip, input logic end_on_last);
    logic [15:0] clean, rx, fcs;
    logic b;
    int nb;
    clean = 16'hFFFF;
    for (int i = 0; i < n*8; i++) clean = step(clean, data[i/8][i%8]);
    fcs = ~clean;
    nb = n*8 + 16;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    rx = 16'hFFFF;
    for (int i = 0; i < nb; i++) begin
      b = (i < n*8) ? data[i/8][i%8] : fcs[i - n*8];
      if (i == flip) b = ~b;
      if (i == nb - 1) rem_before = rx;
      rx = step(rx, b);
      cyc(1'b1, b, 1'b0, (i == nb - 1) && end_on_last);
    end
    last_rem = rx;
  endtask

  task automatic shift16(input logic [15:0] pat);
    for (int i = 0; i < 16; i++) cyc(1'b1, pat[i], 1'b0, 1'b0);
  endtask

  task automatic t_reset;
    check("R9 reset verdict", crc_ok, 1'b0);
    corrupt_mask = 16'hFFFF ^ GOOD;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 reset preset via mask", crc_ok, 1'b1);
    corrupt_mask = 16'h0;
  endtask

  task automatic t_good_frames;
    for (int i = 0; i < 16; i++) data[i] = 8'(i * 37 + 5);
    send_frame(3, -1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R1 R4 good 3-octet frame", crc_ok, 1'b1);
    data[0] = 8'h00; data[1] = 8'hFF; data[2] = 8'h7E; data[3] = 8'h81;
    send_frame(9, -1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R1 R4 good 9-octet frame", crc_ok, 1'b1);
  endtask

  task automatic t_bad_frames;
    send_frame(4, 13, 1'b0);
    check("R3 verdict held without end strobe", crc_ok, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 data bit error", crc_ok, 1'b0);
    send_frame(4, 4*8 + 15, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 FCS bit error", crc_ok, 1'b0);
  endtask

  task automatic t_mask;
    send_frame(2, -1, 1'b0);
    corrupt_mask = 16'h0001;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 mask fails good frame", crc_ok, 1'b0);
    corrupt_mask = 16'h8000;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 top mask bit fails good frame", crc_ok, 1'b0);
    send_frame(5, 9, 1'b0);
    corrupt_mask = last_rem ^ GOOD;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 mask passes matching remainder", crc_ok, 1'b1);
    corrupt_mask = 16'h0;
  endtask

  task automatic t_start_and_end;
    for (int i = 0; i < 11; i++) cyc(1'b1, 1'(i % 3 == 0), 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0);
    send_frame(3, -1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 start with bit and mid-stream restart", crc_ok, 1'b1);
    send_frame(3, -1, 1'b1);
    check("R3 end with last bit excluded", crc_ok, (rem_before == GOOD));
    corrupt_mask = rem_before ^ GOOD;
    send_frame(3, -1, 1'b1);
    check("R3 end compares pre-bit register", crc_ok, 1'b1);
    corrupt_mask = 16'h0;
  endtask

  task automatic t_test_mode;
    test_en = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    shift16(GOOD);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 residue shifted in", crc_ok, 1'b1);
    test_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    test_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i == 7) cyc(1'b0, 1'b0, 1'b1, 1'b0);
      cyc(1'b1, 16'h1234 >> i, 1'b0, 1'b0);
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 R7 pattern without mask, start ignored", crc_ok, 1'b0);
    corrupt_mask = 16'h1234 ^ GOOD;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R6 pattern bit order", crc_ok, 1'b1);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 hold after 16 shifts", crc_ok, 1'b1);
    test_en = 1'b0;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 register kept after exit", crc_ok, 1'b1);
    test_en = 1'b1;
    shift16(16'hA5C3);
    corrupt_mask = 16'hA5C3 ^ GOOD;
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R8 second session shifts 16 more", crc_ok, 1'b1);
    test_en = 1'b0;
    corrupt_mask = 16'hFFFF ^ GOOD;
    cyc(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 preset after test exit", crc_ok, 1'b1);
    corrupt_mask = 16'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_frames();
    t_bad_frames();
    t_mask();
    t_start_and_end();
    t_test_mode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule